// File: doc/BRIEF.md
# Latched Parity Bus Transceiver

This block joins two 8-bit buses, A and B, each of which also carries one parity bit. Two active-low direction enables choose which bus drives the other. Each side has a holding stage. While that side's latch enable is high the stage is transparent. While it is low, the stage supplies the data and parity it captured at the last clock edge on which the enable was high. The parity bit sent to the destination bus comes from one of two places, chosen by a select input: it is computed from the eight source data bits, or it is the source parity bit copied unchanged.

Parity is checked in both modes. The source side always compares the parity it computes against its own parity bit. If the destination stage is transparent, the word that arrives there is checked a second time. This produces the destination error flag, so a single transfer can generate parity and check it on both sides at once. Each bus is modelled as separate input, output and output-enable ports, not as a tri-state net.

Top module: `lpx_top`

## Requirements
- R1: A synchronous active-low reset clears both holding stages to all-zero data and zero parity.
- R2: With both direction enables high, both output enables are 0, all data and parity outputs are 0, and both error flags are 1.
- R3: With both direction enables low (illegal), the outputs behave exactly as in R2.
- R4: With `ab_n`=0 and `ba_n`=1, `b_oe`=1, `a_oe`=0, `b_dout` equals the A-side stage data, and the A outputs are 0.
- R5: With `ba_n`=0 and `ab_n`=1, `a_oe`=1, `b_oe`=0, `a_dout` equals the B-side stage data, and the B outputs are 0.
- R6: With `feed`=0, the destination parity equals the XOR of the 8 stage data bits when `odd`=0. It equals the inverse of that XOR when `odd`=1.
- R7: With `feed`=1, the destination parity equals the source stage parity bit.
- R8: The source error flag (`a_err_n` for A-to-B, `b_err_n` for B-to-A) is 0 exactly when the parity computed from the source stage data differs from the source stage parity. This holds in both modes.
- R9: A latch enable high makes its stage transparent. When the enable is low, the stage supplies the data and parity present at the last rising clock edge on which the enable was high.
- R10: The destination error flag is 1 when the destination latch enable is low. When that enable is high, the flag is 0 exactly when the word driven onto the destination fails its parity check, so it never asserts in generate mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the holding stages |
| rst_n | input | 1 | Synchronous active-low reset |
| ab_n | input | 1 | Active-low enable, A drives B |
| ba_n | input | 1 | Active-low enable, B drives A |
| feed | input | 1 | 0: generate parity, 1: pass source parity |
| odd | input | 1 | 0: even parity, 1: odd parity |
| lat_a | input | 1 | A-side stage transparent when high |
| lat_b | input | 1 | B-side stage transparent when high |
| a_din | input | 8 | A bus data in |
| a_pin | input | 1 | A bus parity in |
| b_din | input | 8 | B bus data in |
| b_pin | input | 1 | B bus parity in |
| a_dout | output | 8 | A bus data out |
| a_pout | output | 1 | A bus parity out |
| a_oe | output | 1 | A bus driven |
| b_dout | output | 8 | B bus data out |
| b_pout | output | 1 | B bus parity out |
| b_oe | output | 1 | B bus driven |
| a_err_n | output | 1 | A-side parity error, active low |
| b_err_n | output | 1 | B-side parity error, active low |

## Verification
The bench targets feed-through words whose parity is wrong. A design that skips checking in that mode would leave both flags high on such a word. The bench also closes the source latch and then changes the bus. A design that computes parity from the live bus, or checks against the live parity pin, would flag the wrong error. It covers a closed destination latch, where a design that ignores the latch enable would raise a stray destination error. It drives both direction enables low, where a design that gives one direction priority would drive a bus.

// File: rtl/lpx_pkg.sv
// Package lpx_pkg
// Shared direction encoding and the parity function for the transceiver.
// Assumes data words are at most 32 bits wide.
package lpx_pkg;

    typedef enum logic [1:0] {
        DIR_IDLE = 2'd0,
        DIR_AB   = 2'd1,
        DIR_BA   = 2'd2,
        DIR_BAD  = 2'd3
    } dir_e;

    // Parity bit that makes the word plus bit even (odd_mode=0) or odd (1).
    function automatic logic par_of(input logic [31:0] word, input logic odd_mode);
        return (^word) ^ odd_mode;
    endfunction

endpackage

// File: rtl/lpx_ctrl.sv
// Module lpx_ctrl
// Decodes the two active-low direction enables into a direction code.
// Assumes both low is an illegal request, which is reported as DIR_BAD.
module lpx_ctrl
    import lpx_pkg::*;
(
    input  logic ab_n,
    input  logic ba_n,
    output dir_e dir
);

    // Map the enable pair onto a direction.
    always_comb begin
        unique case ({ab_n, ba_n})
            2'b11:   dir = DIR_IDLE;
            2'b01:   dir = DIR_AB;
            2'b10:   dir = DIR_BA;
            default: dir = DIR_BAD;
        endcase
    end

endmodule

// File: rtl/lpx_hold.sv
// Module lpx_hold
// One side's holding stage: transparent while le is high. While le is low it
// supplies the word captured at the last clock edge on which le was high.
// Assumes a synchronous active-low reset that clears the stored word.
module lpx_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         le,
    input  logic [W-1:0] d_in,
    input  logic         p_in,
    output logic [W-1:0] held_d,
    output logic         held_p,
    output logic [W-1:0] q_d,
    output logic         q_p
);

    // Capture the incoming word on each edge where the stage is open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_d <= '0;
            held_p <= 1'b0;
        end else if (le) begin
            held_d <= d_in;
            held_p <= p_in;
        end
    end

    // Present the live word when open, the stored word when closed.
    always_comb begin
        q_d = le ? d_in : held_d;
        q_p = le ? p_in : held_p;
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !le |=> (held_d == $past(held_d)) && (held_p == $past(held_p))); // R9

endmodule

// File: rtl/lpx_pchk.sv
// Module lpx_pchk
// Computes the parity of a data word and compares it with a parity bit.
// Assumes W is at most 32.
module lpx_pchk
    import lpx_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] d,
    input  logic         p,
    input  logic         odd,
    output logic         gen,
    output logic         mis
);

    localparam int PADW = 32 - W;

    // Generate the parity bit and flag any disagreement with p.
    always_comb begin
        gen = par_of({{PADW{1'b0}}, d}, odd);
        mis = gen ^ p;
    end

endmodule

// File: rtl/lpx_top.sv
// Module lpx_top
// Transceiver between two W-bit buses, each with one parity bit. It has one
// holding stage per side, generate or feed-through parity toward the
// destination, and checks parity on the source and (if open) destination side.
// Assumes a bus is modelled as separate in/out/enable ports. Undriven outputs
// read zero.
module lpx_top
    import lpx_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ab_n,
    input  logic         ba_n,
    input  logic         feed,
    input  logic         odd,
    input  logic         lat_a,
    input  logic         lat_b,
    input  logic [W-1:0] a_din,
    input  logic         a_pin,
    input  logic [W-1:0] b_din,
    input  logic         b_pin,
    output logic [W-1:0] a_dout,
    output logic         a_pout,
    output logic         a_oe,
    output logic [W-1:0] b_dout,
    output logic         b_pout,
    output logic         b_oe,
    output logic         a_err_n,
    output logic         b_err_n
);

    dir_e dir;

    logic [W-1:0] a_held_d, b_held_d, a_q_d, b_q_d;
    logic         a_held_p, b_held_p, a_q_p, b_q_p;
    logic [W-1:0] a_src_d, b_src_d, a_in_d, b_in_d;
    logic         a_src_p, b_src_p, a_in_p, b_in_p;
    logic         a_src_gen, b_src_gen, a_src_mis, b_src_mis;
    logic         a_gen, b_gen, a_mis, b_mis;
    logic         fwd_ab_p, fwd_ba_p;

    lpx_ctrl u_ctrl (
        .ab_n (ab_n),
        .ba_n (ba_n),
        .dir  (dir)
    );

    // Source views built from bus pins and stored words only (no feedback).
    always_comb begin
        a_src_d = lat_a ? a_din : a_held_d;
        a_src_p = lat_a ? a_pin : a_held_p;
        b_src_d = lat_b ? b_din : b_held_d;
        b_src_p = lat_b ? b_pin : b_held_p;
    end

    lpx_pchk #(.W(W)) u_gen_a (
        .d (a_src_d), .p (a_src_p), .odd (odd), .gen (a_src_gen), .mis (a_src_mis)
    );
    lpx_pchk #(.W(W)) u_gen_b (
        .d (b_src_d), .p (b_src_p), .odd (odd), .gen (b_src_gen), .mis (b_src_mis)
    );

    // Pick the forwarded parity: generated or copied from the source.
    always_comb begin
        fwd_ab_p = feed ? a_src_p : a_src_gen;
        fwd_ba_p = feed ? b_src_p : b_src_gen;
    end

    // Feed each stage from its own bus, or from the word being driven onto it.
    always_comb begin
        a_in_d = (dir == DIR_BA) ? b_src_d  : a_din;
        a_in_p = (dir == DIR_BA) ? fwd_ba_p : a_pin;
        b_in_d = (dir == DIR_AB) ? a_src_d  : b_din;
        b_in_p = (dir == DIR_AB) ? fwd_ab_p : b_pin;
    end

    lpx_hold #(.W(W)) u_hold_a (
        .clk (clk), .rst_n (rst_n), .le (lat_a), .d_in (a_in_d), .p_in (a_in_p),
        .held_d (a_held_d), .held_p (a_held_p), .q_d (a_q_d), .q_p (a_q_p)
    );
    lpx_hold #(.W(W)) u_hold_b (
        .clk (clk), .rst_n (rst_n), .le (lat_b), .d_in (b_in_d), .p_in (b_in_p),
        .held_d (b_held_d), .held_p (b_held_p), .q_d (b_q_d), .q_p (b_q_p)
    );

    lpx_pchk #(.W(W)) u_chk_a (
        .d (a_q_d), .p (a_q_p), .odd (odd), .gen (a_gen), .mis (a_mis)
    );
    lpx_pchk #(.W(W)) u_chk_b (
        .d (b_q_d), .p (b_q_p), .odd (odd), .gen (b_gen), .mis (b_mis)
    );

    // Drive the selected bus and report source and destination errors.
    always_comb begin
        a_dout  = '0;
        a_pout  = 1'b0;
        a_oe    = 1'b0;
        b_dout  = '0;
        b_pout  = 1'b0;
        b_oe    = 1'b0;
        a_err_n = 1'b1;
        b_err_n = 1'b1;
        unique case (dir)
            DIR_AB: begin
                b_oe    = 1'b1;
                b_dout  = a_src_d;
                b_pout  = fwd_ab_p;
                a_err_n = ~a_mis;
                b_err_n = lat_b ? ~b_mis : 1'b1;
            end
            DIR_BA: begin
                a_oe    = 1'b1;
                a_dout  = b_src_d;
                a_pout  = fwd_ba_p;
                b_err_n = ~b_mis;
                a_err_n = lat_a ? ~a_mis : 1'b1;
            end
            default: ;
        endcase
    end

    AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_oe && b_oe)); // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ab_n == ba_n) |-> (!a_oe && !b_oe && a_err_n && b_err_n)); // R2
    AST_GEN_DEST_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (b_oe && !feed && lat_b) |-> b_err_n); // R10
    AST_FEED_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (b_oe && feed && lat_a) |-> (b_pout == a_pin)); // R7
    AST_SRC_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (a_oe && lat_b) |-> (b_err_n == (b_src_gen == b_pin))); // R8

endmodule

// File: tb/lpx_top_tb_top.sv
module lpx_top_tb_top;

    localparam int W = 8;
    localparam int NV = 11;

    typedef struct packed {
        logic       ab_n, ba_n, feed, odd, lat_a, lat_b;
        logic [7:0] a_d;
        logic       a_p;
        logic [7:0] b_d;
        logic       b_p;
        logic       x_aoe, x_boe;
        logic [7:0] x_ad;
        logic       x_ap;
        logic [7:0] x_bd;
        logic       x_bp, x_ea, x_eb;
    } vec_t;

    // Both latches open in every row, so no row depends on history.
    localparam vec_t VEC [NV] = '{
        // ab ba fd od la lb  a_d    ap  b_d    bp  aoe boe x_ad  xap x_bd  xbp ea eb
        '{0,1,0,0,1,1, 8'hA5,0, 8'h00,0, 0,1, 8'h00,0, 8'hA5,0, 1,1}, // R4 R6 even clean
        '{0,1,0,0,1,1, 8'h07,0, 8'h00,0, 0,1, 8'h00,0, 8'h07,1, 0,1}, // R6 R8 R10
        '{0,1,0,1,1,1, 8'h07,0, 8'h00,0, 0,1, 8'h00,0, 8'h07,0, 1,1}, // R6 odd
        '{0,1,1,0,1,1, 8'h07,0, 8'h00,0, 0,1, 8'h00,0, 8'h07,0, 0,0}, // R7 R8 R10
        '{0,1,1,0,1,1, 8'hA5,0, 8'h00,0, 0,1, 8'h00,0, 8'hA5,0, 1,1}, // R7 clean
        '{1,0,0,0,1,1, 8'h00,0, 8'h07,1, 1,0, 8'h07,1, 8'h00,0, 1,1}, // R5 R6
        '{1,0,0,1,1,1, 8'h00,0, 8'hFF,0, 1,0, 8'hFF,1, 8'h00,0, 1,0}, // R5 R8
        '{1,0,1,1,1,1, 8'h00,0, 8'hFF,0, 1,0, 8'hFF,0, 8'h00,0, 0,0}, // R7 R10
        '{1,0,1,0,1,1, 8'h00,0, 8'h01,1, 1,0, 8'h01,1, 8'h00,0, 1,1}, // R7 clean
        '{1,1,0,0,1,1, 8'h07,0, 8'h07,0, 0,0, 8'h00,0, 8'h00,0, 1,1}, // R2
        '{0,0,1,0,1,1, 8'h07,0, 8'h07,0, 0,0, 8'h00,0, 8'h00,0, 1,1}  // R3
    };

    localparam string TAG [NV] = '{"R4/R6", "R6/R8", "R6", "R7/R8", "R7",
                                   "R5/R6", "R5/R8", "R7/R10", "R7", "R2", "R3"};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ab_n = 1'b1, ba_n = 1'b1, feed = 1'b0, odd = 1'b0, lat_a = 1'b0, lat_b = 1'b0;
    logic [W-1:0] a_din = '0, b_din = '0;
    logic a_pin = 1'b0, b_pin = 1'b0;
    logic [W-1:0] a_dout, b_dout;
    logic a_pout, b_pout, a_oe, b_oe, a_err_n, b_err_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    lpx_top #(.W(W)) dut_i (
        .clk (clk), .rst_n (rst_n), .ab_n (ab_n), .ba_n (ba_n), .feed (feed),
        .odd (odd), .lat_a (lat_a), .lat_b (lat_b), .a_din (a_din), .a_pin (a_pin),
        .b_din (b_din), .b_pin (b_pin), .a_dout (a_dout), .a_pout (a_pout),
        .a_oe (a_oe), .b_dout (b_dout), .b_pout (b_pout), .b_oe (b_oe),
        .a_err_n (a_err_n), .b_err_n (b_err_n)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic set_ctl(input logic ab, input logic ba, input logic fd, input logic od,
                           input logic la, input logic lb);
        ab_n = ab; ba_n = ba; feed = fd; odd = od; lat_a = la; lat_b = lb;
    endtask

    task automatic set_bus(input logic [7:0] ad, input logic ap, input logic [7:0] bd,
                           input logic bp);
        a_din = ad; a_pin = ap; b_din = bd; b_pin = bp;
    endtask

    initial begin
        repeat (10000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: stored words are zero after reset; view them through closed latches.
        @(negedge clk);
        set_ctl(0, 1, 1, 0, 0, 0);
        set_bus(8'hFF, 1, 8'hFF, 1);
        #2;
        chk("R1", "b_dout held", b_dout, 0);
        chk("R1", "b_pout held feed", b_pout, 0);
        feed = 0; odd = 1;
        #2;
        chk("R1", "b_pout odd of zero", b_pout, 1);
        chk("R1", "a_err_n held mismatch", a_err_n, 0);
        set_ctl(1, 0, 1, 0, 0, 0);
        #2;
        chk("R1", "a_dout held B", a_dout, 0);
        chk("R1", "a_pout held B", a_pout, 0);

        // Table walk, all latches open.
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            set_ctl(VEC[i].ab_n, VEC[i].ba_n, VEC[i].feed, VEC[i].odd,
                    VEC[i].lat_a, VEC[i].lat_b);
            set_bus(VEC[i].a_d, VEC[i].a_p, VEC[i].b_d, VEC[i].b_p);
            #2;
            chk(TAG[i], "a_oe", a_oe, VEC[i].x_aoe);
            chk(TAG[i], "b_oe", b_oe, VEC[i].x_boe);
            chk(TAG[i], "a_dout", a_dout, VEC[i].x_ad);
            chk(TAG[i], "a_pout", a_pout, VEC[i].x_ap);
            chk(TAG[i], "b_dout", b_dout, VEC[i].x_bd);
            chk(TAG[i], "b_pout", b_pout, VEC[i].x_bp);
            chk(TAG[i], "a_err_n", a_err_n, VEC[i].x_ea);
            chk(TAG[i], "b_err_n", b_err_n, VEC[i].x_eb);
        end

        // R9: capture 3C on A, close, then move the bus.
        @(negedge clk);
        set_ctl(0, 1, 0, 0, 1, 1);
        set_bus(8'h3C, 0, 8'h00, 0);
        @(negedge clk);
        lat_a = 0;
        set_bus(8'hFF, 1, 8'h00, 0);
        #2;
        chk("R9", "b_dout held A", b_dout, 8'h3C);
        chk("R9", "b_pout gen held", b_pout, 0);
        chk("R9", "a_err_n held clean", a_err_n, 1);
        feed = 1;
        #2;
        chk("R9", "b_pout feed held", b_pout, 0);

        // R8: held source word with a bad parity still flags.
        @(negedge clk);
        set_ctl(0, 1, 0, 0, 1, 1);
        set_bus(8'h07, 0, 8'h00, 0);
        @(negedge clk);
        lat_a = 0;
        set_bus(8'h00, 0, 8'h00, 0);
        #2;
        chk("R8", "a_err_n held bad word", a_err_n, 0);

        // R9: B side hold, bad parity captured.
        @(negedge clk);
        set_ctl(1, 0, 0, 0, 1, 1);
        set_bus(8'h00, 0, 8'hA5, 1);
        @(negedge clk);
        lat_b = 0;
        set_bus(8'h00, 0, 8'h00, 0);
        #2;
        chk("R9", "a_dout held B", a_dout, 8'hA5);
        chk("R9", "a_pout gen held B", a_pout, 0);
        chk("R8", "b_err_n held bad", b_err_n, 0);

        // R10: closed destination latch suppresses the destination flag.
        @(negedge clk);
        set_ctl(0, 1, 1, 0, 1, 0);
        set_bus(8'h07, 0, 8'h00, 0);
        #2;
        chk("R10", "a_err_n src", a_err_n, 0);
        chk("R10", "b_err_n dest closed", b_err_n, 1);
        set_ctl(1, 0, 1, 0, 0, 1);
        set_bus(8'h00, 0, 8'h07, 0);
        #2;
        chk("R10", "b_err_n src BA", b_err_n, 0);
        chk("R10", "a_err_n dest closed", a_err_n, 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule